// File: doc/BRIEF.md
# Banked Single-Port Synchronous RAM

This block is a single-port synchronous memory whose width and depth are set by parameters. Internally it is split into equal RAM tiles, each sized so that it fits a fixed 36 Kbit storage tile. One control port carries an access enable, a write flag, an address and write data. A single read-data output returns the word that was addressed in the previous cycle. The upper address bits decode which tile is enabled. A copy of those bits, registered on every clock edge, chooses which tile's output register drives the read port.

When the memory is small enough to fit in at most two 18 Kbit tiles, the block drops the banking and builds one plain array with no select logic. Word i starts out holding the value i, cut to the data width. A small handshake register, cleared by reset, follows the inverse of a ready input. A block-level enable is ANDed with the per-access enable, so a whole memory can be gated off at once.

Top module: `banked_sp_ram`

## Requirements
- R1: In the banked form a tile holds 2^floor(log2(ceil(36864/DATA_W))) words, and the tile count is ceil(DEPTH/words per tile). For DATA_W=32 and DEPTH=2500 this gives three tiles of 1024 words, selected by address bits [11:10].
- R2: When ceil(DEPTH/ceil(18432/DATA_W)) is 2 or less, the memory is one unbanked array with the same port behaviour. For DATA_W=8 and DEPTH=256 every address reads back its own contents with one cycle of latency.
- R3: The address is resized to ceil(log2(DEPTH)) bits. Extra upper bits are dropped and a narrower address is zero-extended. With DEPTH=256 and a 10-bit address, 0x105 and 0x005 reach the same word.
- R4: An access takes place only when both the block enable and the access enable are high. If either is low, nothing is written and no tile output register changes.
- R5: Reads are synchronous. The data addressed at a rising edge is on the read output after that edge and until the next one. Before any write, word i reads as i truncated to DATA_W bits.
- R6: Reads are read-first. A write to a word returns that word's old contents in the same access, and the new value on the next read.
- R7: A write reaches only the tile named by the upper address bits. Words on either side of a tile boundary are independent.
- R8: The tile select is registered from the address on every edge, even when no access is made. A disabled cycle therefore shows the held output of whichever tile its address names.
- R9: When the registered tile select names no existing tile (addresses 3072 to 4095 in the default configuration), the read output keeps its previous value.
- R10: The finish flag is cleared at once by reset. On every rising edge after that, it takes the inverse of the ready input.
- R11: During and after reset the read output is the reset value OUT_INIT (default 0), and the tile select points at tile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Asynchronous reset, active high |
| blk_en_i | input | 1 | Block-level enable, ANDed with the access enable |
| rdy_i | input | 1 | Ready input of the handshake |
| acc_en_i | input | 1 | Per-access enable |
| acc_wr_i | input | 1 | Write flag for the access |
| acc_addr_i | input | ADDR_W | Word address |
| acc_wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, one cycle after the address |
| fin_o | output | 1 | Finish flag, the inverse of the previous ready |

## Verification
A wrong tile decode or a dropped enable term shows up as corrupted contents. The damage appears at the read port only when the affected word is next read, which can be thousands of cycles later. For that reason every address is written and then read back across all tiles and both tile boundaries. A fault in the registered select or in the hold path shows on the very next cycle, as data from the wrong tile or as a changed output for an out-of-range address. Directed sequences place a tile switch or a disabled cycle right after a read to catch this. Because the write path is read-first, a write-first fault shows in the same cycle as the write, as the new value where the old one is expected.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   localparam int SMALL_TILE_BITS = 18432;
   localparam int BIG_TILE_BITS   = 36864;

   function automatic int ceil_div(input int n, input int d);
      return (n + d - 1) / d;
   endfunction

   function automatic int floor_log2(input int x);
      int r;
      r = 0;
      while ((64'd1 << (r + 1)) <= 64'(x)) r++;
      return r;
   endfunction

   function automatic bit is_banked(input int w, input int depth);
      return ceil_div(depth, ceil_div(SMALL_TILE_BITS, w)) > 2;
   endfunction

   function automatic int tile_aw(input int w, input int depth);
      if (!is_banked(w, depth)) return $clog2(depth);
      return floor_log2(ceil_div(BIG_TILE_BITS, w));
   endfunction

endpackage

// File: rtl/bsr_tile.sv
module bsr_tile #(
   parameter int              W        = 32,
   parameter int              AW       = 10,
   parameter int              BASE     = 0,
   parameter logic [W-1:0]    OUT_INIT = '0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          en_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  wdata_i,
   output logic [W-1:0]  q_o
);
   localparam int WORDS = 1 << AW;

   logic [W-1:0] mem [WORDS];

   // contents start as the global word index
   initial begin
      for (int i = 0; i < WORDS; i++) mem[i] = W'(BASE + i);
   end

   always_ff @(posedge clk_i) begin
      if (en_i && we_i) mem[addr_i] <= wdata_i;
   end

   // read-first: the old word is captured in the same edge as a write
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)     q_o <= OUT_INIT;
      else if (en_i) q_o <= mem[addr_i];
   end
endmodule

// File: rtl/bsr_out_sel.sv
module bsr_out_sel #(
   parameter int           W        = 32,
   parameter int           NT       = 3,
   parameter int           SW       = 2,
   parameter logic [W-1:0] OUT_INIT = '0
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic [NT-1:0][W-1:0]  tile_q_i,
   input  logic [SW-1:0]         sel_i,
   output logic [W-1:0]          rd_o
);
   logic [W-1:0] hold_q;

   // an index with no tile behind it leaves the last output in place
   always_comb begin
      rd_o = hold_q;
      for (int k = 0; k < NT; k++) begin
         if (sel_i == SW'(k)) rd_o = tile_q_i[k];
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) hold_q <= OUT_INIT;
      else       hold_q <= rd_o;
   end
endmodule

// File: rtl/banked_sp_ram.sv
module banked_sp_ram
   import bsr_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                DEPTH    = 2500,
   parameter int                ADDR_W   = 12,
   parameter logic [DATA_W-1:0] OUT_INIT = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              blk_en_i,
   input  logic              rdy_i,
   input  logic              acc_en_i,
   input  logic              acc_wr_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic [DATA_W-1:0] acc_wdata_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              fin_o
);
   localparam bit BANKED     = is_banked(DATA_W, DEPTH);
   localparam int FULL_AW    = $clog2(DEPTH);
   localparam int TILE_AW    = tile_aw(DATA_W, DEPTH);
   localparam int TILE_WORDS = 1 << TILE_AW;
   localparam int NUM_TILES  = BANKED ? ceil_div(DEPTH, TILE_WORDS) : 1;
   localparam int SEL_W      = BANKED ? FULL_AW - TILE_AW : 1;

   if (DEPTH < 2)         begin : g_chk_depth $error("DEPTH must be at least 2"); end
   if (DATA_W < 1)        begin : g_chk_width $error("DATA_W must be positive"); end
   if (TILE_AW > FULL_AW) begin : g_chk_tile  $error("tile wider than memory"); end

   logic [FULL_AW-1:0]                full_addr;
   logic                              gen_en;
   logic                              wr_en;
   logic [NUM_TILES-1:0]              tile_en;
   logic [NUM_TILES-1:0][DATA_W-1:0]  tile_q;
   logic [SEL_W-1:0]                  sel_q;

   // address resize to the full width
   if (ADDR_W >= FULL_AW) begin : g_addr_trunc
      assign full_addr = acc_addr_i[FULL_AW-1:0];
   end else begin : g_addr_ext
      assign full_addr = {{(FULL_AW-ADDR_W){1'b0}}, acc_addr_i};
   end

   assign gen_en = blk_en_i & acc_en_i;
   assign wr_en  = gen_en & acc_wr_i;

   if (BANKED) begin : g_banked
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) sel_q <= '0;
         else       sel_q <= full_addr[FULL_AW-1:TILE_AW];
      end

      for (genvar k = 0; k < NUM_TILES; k++) begin : g_tile
         assign tile_en[k] = gen_en && (full_addr[FULL_AW-1:TILE_AW] == SEL_W'(k));
         bsr_tile #(
            .W(DATA_W), .AW(TILE_AW), .BASE(k * TILE_WORDS), .OUT_INIT(OUT_INIT)
         ) u_tile (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .en_i    (tile_en[k]),
            .we_i    (wr_en),
            .addr_i  (full_addr[TILE_AW-1:0]),
            .wdata_i (acc_wdata_i),
            .q_o     (tile_q[k])
         );
      end

      bsr_out_sel #(
         .W(DATA_W), .NT(NUM_TILES), .SW(SEL_W), .OUT_INIT(OUT_INIT)
      ) u_sel (
         .clk_i    (clk_i),
         .rst_i    (rst_i),
         .tile_q_i (tile_q),
         .sel_i    (sel_q),
         .rd_o     (rd_data_o)
      );
   end else begin : g_flat
      assign sel_q      = '0;
      assign tile_en[0] = gen_en;
      bsr_tile #(
         .W(DATA_W), .AW(FULL_AW), .BASE(0), .OUT_INIT(OUT_INIT)
      ) u_tile (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .en_i    (gen_en),
         .we_i    (wr_en),
         .addr_i  (full_addr),
         .wdata_i (acc_wdata_i),
         .q_o     (tile_q[0])
      );
      assign rd_data_o = tile_q[0];
   end

   // handshake flag
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) fin_o <= 1'b0;
      else       fin_o <= ~rdy_i;
   end
endmodule

// File: rtl/bsr_chk.sv
module bsr_chk #(
   parameter int NT = 1,
   parameter int SW = 1,
   parameter int W  = 8
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          blk_en_i,
   input logic          gen_en,
   input logic          rdy_i,
   input logic          fin_o,
   input logic [NT-1:0] tile_en,
   input logic [SW-1:0] sel_q,
   input logic [W-1:0]  rd
);
   // R4: block enable low keeps every tile idle
   a_r4_block_gate: assert property (@(posedge clk_i) disable iff (rst_i)
      !blk_en_i |-> (tile_en == '0));

   // R7: at most one tile is enabled per access
   a_r7_one_tile: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(tile_en));

   // R10: finish flag is the inverse of the previous ready
   a_r10_fin_tracks: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> (fin_o == !$past(rdy_i)));

   // R9: a select with no tile behind it leaves the output unchanged
   a_r9_hold_out: assert property (@(posedge clk_i) disable iff (rst_i)
      (32'(sel_q) >= NT) |-> $stable(rd));

   // R8: no access and the same select leave the output unchanged
   a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(gen_en) && $stable(sel_q)) |-> $stable(rd));
endmodule

bind banked_sp_ram bsr_chk #(.NT(NUM_TILES), .SW(SEL_W), .W(DATA_W)) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .blk_en_i (blk_en_i),
   .gen_en   (gen_en),
   .rdy_i    (rdy_i),
   .fin_o    (fin_o),
   .tile_en  (tile_en),
   .sel_q    (sel_q),
   .rd       (rd_data_o)
);

// File: tb/sim_banked_sp_ram.sv
module sim_banked_sp_ram;
   localparam int CLK_PERIOD = 10;
   localparam int NT0 = 3;
   localparam int PHYS0 = 3072;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rdy = 1'b1;

   logic        be0 = 0, ae0 = 0, wr0 = 0;
   logic [11:0] ad0 = '0;
   logic [31:0] wd0 = '0;
   logic [31:0] rd0;
   logic        fin0;

   logic        be1 = 0, ae1 = 0, wr1 = 0;
   logic [9:0]  ad1 = '0;
   logic [7:0]  wd1 = '0;
   logic [7:0]  rd1;
   logic        fin1;

   int vecs = 0;
   int fails = 0;
   int cycles = 0;

   // reference state
   logic [31:0] m0 [PHYS0];
   logic [31:0] tq0 [NT0];
   int          sel0;
   logic [31:0] exp0;
   logic [7:0]  m1 [256];
   logic [7:0]  exp1;

   always #(CLK_PERIOD/2) clk = ~clk;

   banked_sp_ram #(.DATA_W(32), .DEPTH(2500), .ADDR_W(12)) u0 (
      .clk_i(clk), .rst_i(rst), .blk_en_i(be0), .rdy_i(rdy),
      .acc_en_i(ae0), .acc_wr_i(wr0), .acc_addr_i(ad0), .acc_wdata_i(wd0),
      .rd_data_o(rd0), .fin_o(fin0));

   banked_sp_ram #(.DATA_W(8), .DEPTH(256), .ADDR_W(10)) u1 (
      .clk_i(clk), .rst_i(rst), .blk_en_i(be1), .rdy_i(rdy),
      .acc_en_i(ae1), .acc_wr_i(wr1), .acc_addr_i(ad1), .acc_wdata_i(wd1),
      .rd_data_o(rd1), .fin_o(fin1));

   function automatic logic [31:0] init_word(input int i);
      return 32'(i);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      vecs++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   // one access on u0; starts and ends at a falling edge
   task automatic cyc0(input bit be, input bit ae, input bit w,
                       input logic [11:0] a, input logic [31:0] d, input string req);
      int k;
      be0 = be; ae0 = ae; wr0 = w; ad0 = a; wd0 = d;
      @(posedge clk);
      k = int'(a[11:10]);
      if (be && ae && k < NT0) begin
         tq0[k] = m0[a];
         if (w) m0[a] = d;
      end
      sel0 = k;
      if (sel0 < NT0) exp0 = tq0[sel0];
      @(negedge clk);
      chk(req, rd0, exp0);
   endtask

   task automatic cyc1(input bit en, input bit w, input logic [9:0] a,
                       input logic [7:0] d, input string req);
      be1 = 1'b1; ae1 = en; wr1 = w; ad1 = a; wd1 = d;
      @(posedge clk);
      if (en) begin
         exp1 = m1[a[7:0]];
         if (w) m1[a[7:0]] = d;
      end
      @(negedge clk);
      chk(req, {24'd0, rd1}, {24'd0, exp1});
      ae1 = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog R1..R11 run got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      void'($urandom(32'd20240611));
      for (int i = 0; i < PHYS0; i++) m0[i] = init_word(i);
      for (int i = 0; i < 256; i++) m1[i] = 8'(i);
      for (int k = 0; k < NT0; k++) tq0[k] = '0;
      sel0 = 0; exp0 = '0; exp1 = '0;

      // R11 / R10: reset state, held across edges
      repeat (3) @(negedge clk);
      chk("R11 reset rd u0", rd0, 32'd0);
      chk("R11 reset rd u1", {24'd0, rd1}, 32'd0);
      chk("R10 reset fin", {31'd0, fin0}, 32'd0);
      rdy = 1'b0;
      @(negedge clk);
      chk("R10 fin held by reset", {31'd0, fin0}, 32'd0);
      rst = 1'b0;
      rdy = 1'b1;
      @(negedge clk);
      chk("R10 fin after ready high", {31'd0, fin0}, 32'd0);
      rdy = 1'b0;
      @(negedge clk);
      chk("R10 fin after ready low", {31'd0, fin0}, 32'd1);
      chk("R10 fin u1", {31'd0, fin1}, 32'd1);
      rdy = 1'b1;
      @(negedge clk);
      chk("R10 fin back low", {31'd0, fin0}, 32'd0);

      // R5: initial contents, one-cycle latency
      for (int i = 0; i < 2500; i++) cyc0(1, 1, 0, 12'(i), '0, "R5 sequential read");

      // R1 / R7: tile boundaries
      cyc0(1, 1, 1, 12'd1023, 32'hAAAA_0001, "R7 write below boundary");
      cyc0(1, 1, 1, 12'd1024, 32'hBBBB_0002, "R7 write above boundary");
      cyc0(1, 1, 1, 12'd2048, 32'hCCCC_0003, "R1 write third tile");
      cyc0(1, 1, 0, 12'd1023, '0, "R1 read tile0 top");
      cyc0(1, 1, 0, 12'd1024, '0, "R1 read tile1 base");
      cyc0(1, 1, 0, 12'd0,    '0, "R7 tile0 base untouched");
      cyc0(1, 1, 0, 12'd2048, '0, "R1 read tile2 base");
      cyc0(1, 1, 0, 12'd2047, '0, "R7 tile1 top untouched");

      // R6: read-first
      cyc0(1, 1, 1, 12'd7, 32'hDEAD_BEEF, "R6 old value on write");
      cyc0(1, 1, 0, 12'd7, '0, "R6 new value next read");

      // R4: each enable alone blocks the write
      cyc0(0, 1, 1, 12'd8, 32'h1111_1111, "R4 block enable low");
      cyc0(1, 0, 1, 12'd9, 32'h2222_2222, "R4 access enable low");
      cyc0(1, 1, 0, 12'd8, '0, "R4 word 8 unchanged");
      cyc0(1, 1, 0, 12'd9, '0, "R4 word 9 unchanged");

      // R8: select follows address during idle cycles
      cyc0(1, 1, 0, 12'd5,    '0, "R8 read tile0");
      cyc0(1, 1, 0, 12'd1030, '0, "R8 read tile1");
      cyc0(0, 0, 0, 12'd5,    '0, "R8 idle shows tile0 register");
      cyc0(0, 0, 0, 12'd2100, '0, "R8 idle shows tile2 register");

      // R9: index without tile keeps output
      cyc0(1, 1, 0, 12'd20,   '0, "R9 read before");
      cyc0(1, 1, 1, 12'd3500, 32'h5555_5555, "R9 unmatched holds");
      cyc0(1, 1, 0, 12'd3600, '0, "R9 still holds");
      cyc0(1, 1, 0, 12'd20,   '0, "R9 back in range");

      // R7 / R1: random fill of every tile, then read back
      for (int i = 0; i < PHYS0; i++) cyc0(1, 1, 1, 12'(i), $urandom, "R7 random fill");
      for (int i = 0; i < PHYS0; i++) cyc0(1, 1, 0, 12'(i), '0, "R7 random readback");

      // mixed random traffic including idle and out-of-range accesses
      for (int i = 0; i < 1500; i++) begin
         rv = $urandom;
         cyc0(rv[0] | rv[1], rv[2] | rv[3], rv[4], 12'($urandom), $urandom, "R8 R9 random mix");
      end

      // R2 / R3: unbanked instance with truncated address
      cyc1(1, 0, 10'd3,   '0, "R2 unbanked read");
      cyc1(1, 0, 10'd255, '0, "R2 unbanked top word");
      cyc1(1, 1, 10'h105, 8'hA5, "R3 write with upper bits set");
      cyc1(1, 0, 10'h005, '0, "R3 aliased read");
      cyc1(1, 1, 10'h005, 8'h3C, "R2 unbanked read-first");
      cyc1(1, 0, 10'h305, '0, "R3 alias reads new");
      cyc1(0, 0, 10'h010, '0, "R2 idle keeps output");

      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule